// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions on a two-wire PHY management bus. A requester presents a read or write flag, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit data word. The block then produces one complete management frame: a serial clock made from the system clock by a programmable divider, a serial data output with its own output-enable so that a board-level tri-state buffer can release the shared line, and a sampled data input. When the frame is over, a one-cycle done pulse marks the result and, for a read, the 16 bits gathered from the PHY.

Each frame is a fixed series of bit slots, and every slot states whether the line is driven. A read frame lasts 64 slots and has a single released turnaround slot. A write frame lasts 65 slots and has two released turnaround slots. Both frame types end with one extra released clock slot, after which the clock, data and enable all return low. Only one transaction runs at a time. A ready output holds off new requests until the done pulse. Arbitration between several requesters is not part of this block.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, mdc, mdio_out, mdio_oe and rsp_done are low, req_ready is high and rsp_rdata is zero.
- R2: Slots 0 to 31 of every frame drive a one with mdio_oe high (preamble).
- R3: Slots 32 and 33 drive 0 then 1 (start). Slots 34 and 35 drive 1 then 0 for a read and 0 then 1 for a write. mdio_oe is high in all four slots.
- R4: Slots 36 to 40 carry the PHY address and slots 41 to 45 carry the register number, each MSB first with mdio_oe high.
- R5: In a write frame, slots 46 and 47 have mdio_oe and mdio_out low, and slots 48 to 63 drive the write data MSB first with mdio_oe high.
- R6: In a read frame, slot 46 and data slots 47 to 62 have mdio_oe and mdio_out low. mdio_in is sampled on the last system clock of the high phase of each data slot. The first sample becomes bit 15 of rsp_rdata.
- R7: The last slot of a frame (slot 63 for a read, slot 64 for a write) has mdio_oe and mdio_out low. For one cycle after that slot, mdc, mdio_out and mdio_oe are all low before the done pulse.
- R8: Each slot holds mdc low for HALF_DIV system clocks and then high for HALF_DIV system clocks. mdio_out and mdio_oe change only at slot boundaries.
- R9: rsp_done is high for exactly one cycle, the cycle after the post-frame idle cycle, and req_ready is high in that cycle.
- R10: A request is taken when req_valid and req_ready are both high at a clock edge. From the next cycle req_ready stays low until the done cycle, and req_valid is ignored while req_ready is low.
- R11: rsp_rdata changes only in a done cycle that ends a read frame. A write frame leaves it unchanged whatever mdio_in does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken on this edge |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | ADDR_W | PHY address |
| req_reg | input | ADDR_W | Register number inside the PHY |
| req_wdata | input | DATA_W | Data for a write frame |
| rsp_done | output | 1 | One-cycle end-of-transaction pulse |
| rsp_rdata | output | DATA_W | Last read result |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_out |
| mdio_in | input | 1 | Serial data from the PHY |

## Verification
Take the request as accepted at clock edge k. Slot s then shows its pin values in the cycles that follow edges k+2·H·s through k+2·H·s+2·H−1, with mdc high in the second half. The input bit of a read data slot is captured at edge k+2·H·(s+1). The all-low idle cycle follows edge k+2·H·N, where N is 64 or 65, and the done pulse with the result follows edge k+2·H·N+1. The reference model in the bench counts cycles from the acceptance edge using these offsets and compares every pin at the falling clock edge of each cycle. The PHY model changes mdio_in only at the start of a slot, so each captured bit is stable at the edge where it is taken.

// File: rtl/mdio_fm_pkg.sv
// Package: shared types for the management frame master.
// Assumes: imported by every module of the block.
package mdio_fm_pkg;

    // Sequencer states: waiting, shifting slots, post-frame idle cycle
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } fm_state_t;

    // Per-slot control decoded from the slot index
    typedef struct packed {
        logic drive;   // value for the data pin
        logic oe;      // data pin is driven in this slot
        logic sample;  // input is captured at the end of this slot
        logic last;    // final slot of the frame
    } slot_ctl_t;

endpackage

// File: rtl/mdio_div.sv
// Module: mdio_div
// Makes the slot timing from the system clock. Each slot is a low phase
// followed by a high phase, each HALF_DIV system clocks long.
// Assumes: run is high for the whole frame; dropping run clears the phase.
module mdio_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_high,
    output logic slot_end
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;

    // Half-period counter and phase toggle; cleared whenever not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Slot ends on the last system clock of the high phase
    always_comb begin
        phase_high = phase_q;
        slot_end   = run && phase_q && (cnt_q == CNT_LAST);
    end
endmodule

// File: rtl/mdio_slot_map.sv
// Module: mdio_slot_map
// Purely combinational decoder: slot index plus latched request give the
// data value, drive enable, sample flag and last-slot flag of that slot.
// Assumes: slot never exceeds the last slot of the current frame type.
module mdio_slot_map
    import mdio_fm_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int SLOT_W  = 7
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic              wr,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regn,
    input  logic [DATA_W-1:0] wdata,
    output slot_ctl_t         ctl
);
    localparam int OP_END  = PRE_LEN + 4;
    localparam int PHY_END = OP_END + ADDR_W;
    localparam int HDR_END = PHY_END + ADDR_W;
    localparam int RD_LAST = HDR_END + DATA_W + 1;
    localparam int WR_LAST = HDR_END + DATA_W + 2;

    // Slot decode by region: preamble, start, opcode, addresses, payload
    always_comb begin
        int s;
        int off;
        logic [ADDR_W-1:0] a_sh;
        logic [DATA_W-1:0] d_sh;
        s    = int'(slot);
        off  = 0;
        a_sh = '0;
        d_sh = '0;
        ctl  = '0;
        if (s < PRE_LEN) begin
            ctl.oe    = 1'b1;
            ctl.drive = 1'b1;
        end else if (s < PRE_LEN + 2) begin
            ctl.oe    = 1'b1;
            ctl.drive = (s == PRE_LEN + 1);
        end else if (s < OP_END) begin
            ctl.oe    = 1'b1;
            ctl.drive = wr ? (s == PRE_LEN + 3) : (s == PRE_LEN + 2);
        end else if (s < PHY_END) begin
            a_sh      = phy << (s - OP_END);
            ctl.oe    = 1'b1;
            ctl.drive = a_sh[ADDR_W-1];
        end else if (s < HDR_END) begin
            a_sh      = regn << (s - PHY_END);
            ctl.oe    = 1'b1;
            ctl.drive = a_sh[ADDR_W-1];
        end else begin
            off = s - HDR_END;
            if (wr) begin
                if (off >= 2 && off < 2 + DATA_W) begin
                    d_sh      = wdata << (off - 2);
                    ctl.oe    = 1'b1;
                    ctl.drive = d_sh[DATA_W-1];
                end
            end else begin
                ctl.sample = (off >= 1) && (off <= DATA_W);
            end
        end
        ctl.last = wr ? (s == WR_LAST) : (s == RD_LAST);
    end
endmodule

// File: rtl/mdio_frame_master.sv
// Module: mdio_frame_master (top)
// Runs one clause-22 style management frame per accepted request: the
// preamble, start, opcode, addresses, turnaround and data slots, one
// released trailing slot, one all-low idle cycle, then a done pulse.
// Assumes: mdio_in is already synchronous to clk and is stable across the
// high phase of the management clock.
module mdio_frame_master
    import mdio_fm_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int PRE_LEN  = 32,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    localparam int N_WR   = PRE_LEN + 4 + 2 * ADDR_W + DATA_W + 3;
    localparam int SLOT_W = $clog2(N_WR);

    fm_state_t         state_q;
    logic [SLOT_W-1:0] slot_q;
    logic              wr_q;
    logic [ADDR_W-1:0] phy_q;
    logic [ADDR_W-1:0] reg_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              run;
    logic              phase_high;
    logic              slot_end;
    slot_ctl_t         ctl;

    assign run = (state_q == ST_RUN);

    mdio_div #(
        .HALF_DIV(HALF_DIV)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .phase_high(phase_high),
        .slot_end  (slot_end)
    );

    mdio_slot_map #(
        .PRE_LEN(PRE_LEN),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W)
    ) u_map (
        .slot (slot_q),
        .wr   (wr_q),
        .phy  (phy_q),
        .regn (reg_q),
        .wdata(wd_q),
        .ctl  (ctl)
    );

    // Sequencer: take a request, step through slots, idle cycle, done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            wr_q    <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            wd_q    <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        phy_q   <= req_phy;
                        reg_q   <= req_reg;
                        wd_q    <= req_wdata;
                        slot_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (slot_end) begin
                        if (ctl.last) begin
                            state_q <= ST_FIN;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    if (!wr_q) begin
                        rdata_q <= cap_q;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Input capture: shift in one bit at the end of each sampling slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (slot_end && ctl.sample) begin
            cap_q <= {cap_q[DATA_W-2:0], mdio_in};
        end
    end

    // Pin and handshake outputs, all low outside a running frame
    always_comb begin
        mdc       = run && phase_high;
        mdio_out  = run && ctl.drive;
        mdio_oe   = run && ctl.oe;
        req_ready = (state_q == ST_IDLE);
        rsp_done  = done_q;
        rsp_rdata = rdata_q;
    end
endmodule

// File: rtl/mdio_frame_master_chk.sv
// Module: mdio_frame_master_chk
// Protocol checker bound to the frame master; it watches ports only.
// Assumes: the synchronous active-low reset is held during the first edges.
module mdio_frame_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              mdc,
    input logic              mdio_out,
    input logic              mdio_oe
);
    // R1: idle means all pins low
    a_r1_idle_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mdc && !mdio_out && !mdio_oe));

    // R8: data and enable do not move while the clock is high
    a_r8_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R7: the cycle before done is the all-low idle cycle
    a_r7_idle_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(!mdc && !mdio_oe && !mdio_out && !req_ready));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9: ready is high in the done cycle
    a_r9_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R10: an accepted request drops ready in the next cycle
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: the result moves only in a done cycle
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> $stable(rsp_rdata));
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .rsp_rdata(rsp_rdata),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
);

// File: tb/mdio_frame_master_tb.sv
// Bench: a behavioural frame model (bit queues plus cycle offsets) checked
// against the pins on every falling clock edge.
module mdio_frame_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 3;
    localparam int WD_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [15:0] last_rd = '0;

    bit e_drv[$];
    bit e_oe[$];
    bit e_smp[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdio_frame_master #(
        .HALF_DIV(HALF),
        .PRE_LEN (32),
        .ADDR_W  (5),
        .DATA_W  (16)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_write(req_write),
        .req_phy  (req_phy),
        .req_reg  (req_reg),
        .req_wdata(req_wdata),
        .rsp_done (rsp_done),
        .rsp_rdata(rsp_rdata),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .mdio_in  (mdio_in)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void push(input bit d, input bit o, input bit s);
        e_drv.push_back(d);
        e_oe.push_back(o);
        e_smp.push_back(s);
    endfunction

    function automatic string slot_tag(input bit wr, input int s);
        if (s < 32) return "R2";
        if (s < 36) return "R3";
        if (s < 46) return "R4";
        if (wr) return (s < 64) ? "R5" : "R7";
        return (s < 63) ? "R6" : "R7";
    endfunction

    task automatic run_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [15:0] phy_rd, input bit poke);
        int n;
        int last_j;
        int bidx;
        logic [15:0] exp_rd;
        e_drv.delete(); e_oe.delete(); e_smp.delete();
        for (int i = 0; i < 32; i++) push(1, 1, 0);
        push(0, 1, 0); push(1, 1, 0);
        if (wr) begin push(0, 1, 0); push(1, 1, 0); end
        else    begin push(1, 1, 0); push(0, 1, 0); end
        for (int i = 4; i >= 0; i--) push(phy[i], 1, 0);
        for (int i = 4; i >= 0; i--) push(rg[i], 1, 0);
        if (wr) begin
            push(0, 0, 0); push(0, 0, 0);
            for (int i = 15; i >= 0; i--) push(wd[i], 1, 0);
        end else begin
            push(0, 0, 0);
            for (int i = 0; i < 16; i++) push(0, 0, 1);
        end
        push(0, 0, 0);
        n = e_drv.size();
        chk("R7", n, wr ? 65 : 64, "frame slot count");
        exp_rd = wr ? last_rd : phy_rd;
        chk("R10", int'(req_ready), 1, "ready before request");
        req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        last_j = 2 * HALF * n + 1;
        bidx = 15;
        for (int j = 0; j <= last_j; j++) begin
            if (j < 2 * HALF * n) begin
                int s;
                int ph;
                s = j / (2 * HALF);
                ph = j % (2 * HALF);
                chk("R8", int'(mdc), (ph >= HALF) ? 1 : 0, "mdc phase");
                chk(slot_tag(wr, s), int'(mdio_out), int'(e_drv[s]), $sformatf("mdio_out slot %0d", s));
                chk(slot_tag(wr, s), int'(mdio_oe), int'(e_oe[s]), $sformatf("mdio_oe slot %0d", s));
                chk("R10", int'(req_ready), 0, "ready while busy");
                chk("R9", int'(rsp_done), 0, "done while busy");
                if (ph == 0) begin
                    if (e_smp[s]) begin
                        mdio_in = phy_rd[bidx];
                        bidx--;
                    end else begin
                        mdio_in = s[0] ^ s[2] ^ wr;
                    end
                end
                if (poke && j == 7) begin
                    req_write = ~wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
                    req_valid = 1'b1;
                end
            end else if (j == 2 * HALF * n) begin
                chk("R7", int'({mdc, mdio_out, mdio_oe}), 0, "idle cycle pins");
                chk("R9", int'(rsp_done), 0, "done in idle cycle");
                chk("R10", int'(req_ready), 0, "ready in idle cycle");
            end else begin
                req_valid = 1'b0;
                chk("R9", int'(rsp_done), 1, "done pulse");
                chk("R9", int'(req_ready), 1, "ready in done cycle");
                chk("R7", int'({mdc, mdio_out, mdio_oe}), 0, "pins in done cycle");
                chk(wr ? "R11" : "R6", int'(rsp_rdata), int'(exp_rd), "result word");
            end
            if (j != last_j) begin
                @(posedge clk); @(negedge clk);
            end
        end
        if (!wr) last_rd = phy_rd;
    endtask

    task automatic idle_gap(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R9", int'(rsp_done), 0, "done stays low when idle");
            chk("R1", int'({mdc, mdio_out, mdio_oe}), 0, "idle pins");
            chk("R11", int'(rsp_rdata), int'(last_rd), "result held when idle");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", int'(mdc), 0, "mdc after reset");
        chk("R1", int'(mdio_out), 0, "mdio_out after reset");
        chk("R1", int'(mdio_oe), 0, "mdio_oe after reset");
        chk("R1", int'(req_ready), 1, "ready after reset");
        chk("R1", int'(rsp_done), 0, "done after reset");
        chk("R1", int'(rsp_rdata), 0, "rdata after reset");
        idle_gap(2);
        run_frame(1'b0, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 1'b0);
        run_frame(1'b1, 5'h1F, 5'h00, 16'h8001, 16'h0000, 1'b0);
        idle_gap(3);
        run_frame(1'b0, 5'h10, 5'h1F, 16'h1234, 16'hFFFF, 1'b1);
        run_frame(1'b0, 5'h0A, 5'h15, 16'h0000, 16'h0001, 1'b0);
        run_frame(1'b1, 5'h00, 5'h00, 16'h5A5A, 16'h0000, 1'b1);
        idle_gap(2);
        run_frame(1'b0, 5'h15, 5'h0A, 16'h0000, 16'h8000, 1'b0);
        run_frame(1'b1, 5'h03, 5'h12, 16'h0000, 16'h0000, 1'b0);
        idle_gap(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule